// File: doc/BRIEF.md
# Equalizer Position Encoder and Burst Writer

This block sits on the host side of a five-band stereo equalizer that is programmed over I2C. Software supplies a signed position per band, from −5 (full cut) through 0 (flat) to +5 (full boost), together with a quality-factor mode. The block turns each position into a 3-bit boost step and a 3-bit cut step. The pairing it picks depends on the mode: plain variable-Q, constant-Q, or an intermediate quasi-constant-Q mapping.

A single-cycle `go` pulse captures the positions, the mode, the bypass request and the address-select level. The block then streams one auto-increment write frame in byte form to a downstream I2C byte master, using a valid/ready handshake. The frame is the device address, a zero register index, and then the five band bytes in band order. First-byte and last-byte markers travel with the frame. If the byte master reports a missing acknowledge, the frame stops, a one-cycle error pulse is raised, and the block returns to idle.

Top module: `eq_burst_writer`

## Requirements
- R1: A position of 0 encodes as boost 0 and cut 0 in every mode.
- R2: In variable-Q mode (mode 0, and also the spare code mode 3), position +p encodes as boost p, cut 0, and position −p encodes as boost 0, cut p.
- R3: In constant-Q mode (mode 1), position +p encodes as boost 5, cut 5−p, and position −p encodes as boost 5−p, cut 5.
- R4: In quasi-constant-Q mode (mode 2), positions map as follows, written as (boost,cut):
  - +5 → (5,0), +4 → (5,1), +3 → (5,2), +2 → (4,2), +1 → (3,2)
  - −1 → (2,3), −2 → (2,4), −3 → (2,5), −4 → (1,5), −5 → (0,5)
- R5: A 4-bit signed position above +5 is treated as +5, and one below −5 is treated as −5, before encoding. No step ever exceeds 5.
- R6: Each band byte carries the boost step in bits 6:4 and the cut step in bits 2:0, with bit 3 at 0. Bit 7 of the first band's byte carries the captured bypass request. Bit 7 is 0 in every other band byte.
- R7: A frame is exactly seven bytes:
  - the address, 0x84 when address-select was low at `go` and 0x86 when it was high
  - 0x00
  - bands 1 to 5 in order
- R8: A byte stays on `out_data` with `out_valid` high until `out_ready` accepts it. `out_first` marks the address byte and `out_last` marks the fifth band byte.
- R9: `busy` rises on the clock edge that samples `go` and falls on the edge that accepts the last byte. A `go` while busy is ignored and does not disturb the frame in flight.
- R10: `ack_err` while busy ends the frame at that edge: `busy` and `out_valid` drop, and `err` is high for exactly one cycle.
- R11: After reset, `busy`, `out_valid`, `out_first`, `out_last` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start strobe, sampled when idle |
| qmode | input | 2 | 0 variable-Q, 1 constant-Q, 2 quasi-constant-Q, 3 as 0 |
| bypass_req | input | 1 | Requested flat-response bypass bit |
| addr_sel | input | 1 | Device address select level |
| band_pos | input | 20 | Five signed 4-bit positions, band 1 in bits 3:0 |
| ack_err | input | 1 | Missing-acknowledge report from the byte master |
| out_ready | input | 1 | Byte master can take a byte |
| out_data | output | 8 | Byte to send |
| out_valid | output | 1 | `out_data` is valid |
| out_first | output | 1 | Current byte opens the frame |
| out_last | output | 1 | Current byte closes the frame |
| busy | output | 1 | Frame in progress |
| err | output | 1 | One-cycle abort indication |

## Verification
A faulty encoder appears as a wrong band byte in the very frame that follows `go`. Each band slot is compared against steps recomputed from the mode rules, across every 4-bit position value in every mode. A bad byte counter or slot register shows up as a misplaced or repeated byte, or as a marker on the wrong byte, and this is visible at the first stalled or accepted transfer. Broken busy or abort state is caught one cycle after the last accept or after `ack_err`. It shows as a lingering `busy`, a stretched `err` pulse, or a relaunched frame when a mid-frame `go` arrives.

// File: rtl/eqw_pkg.sv
package eqw_pkg;
  localparam int STEP_MAX = 5;

  typedef enum logic [1:0] {
    Q_VAR   = 2'd0,
    Q_CONST = 2'd1,
    Q_QUASI = 2'd2,
    Q_SPARE = 2'd3
  } qmode_e;

  typedef struct packed {
    logic [2:0] boost;
    logic [2:0] cut;
  } steps_t;

  // Saturate a signed position into the legal step range.
  function automatic int clamp_pos(int p);
    if (p > STEP_MAX)  return STEP_MAX;
    if (p < -STEP_MAX) return -STEP_MAX;
    return p;
  endfunction

  // Map a clamped position to a boost/cut pair for one Q-mode.
  function automatic steps_t encode_pos(int p, logic [1:0] mode);
    steps_t s;
    int     m;
    int     b;
    int     c;
    m = (p < 0) ? -p : p;
    b = 0;
    c = 0;
    if (p != 0) begin
      case (mode)
        Q_CONST: begin
          b = (p > 0) ? STEP_MAX : STEP_MAX - m;
          c = (p > 0) ? STEP_MAX - m : STEP_MAX;
        end
        Q_QUASI: begin
          if (p >= 3) begin
            b = STEP_MAX;
            c = STEP_MAX - p;
          end else if (p > 0) begin
            b = p + 2;
            c = 2;
          end else begin
            b = (m <= 3) ? 2 : STEP_MAX - m;
            c = (m <= 3) ? m + 2 : STEP_MAX;
          end
        end
        default: begin
          b = (p > 0) ? m : 0;
          c = (p < 0) ? m : 0;
        end
      endcase
    end
    s.boost = 3'(b);
    s.cut   = 3'(c);
    return s;
  endfunction

  function automatic logic [7:0] pack_band(steps_t s, logic top_bit);
    return {top_bit, s.boost, 1'b0, s.cut};
  endfunction
endpackage

// File: rtl/eqw_band_enc.sv
module eqw_band_enc
  import eqw_pkg::*;
#(
  parameter int POS_W = 4
) (
  input  logic signed [POS_W-1:0] pos,
  input  logic [1:0]              mode,
  output steps_t                  steps
);
  int pos_clamped;

  always_comb begin
    pos_clamped = clamp_pos(int'(pos));
    steps       = encode_pos(pos_clamped, mode);
  end
endmodule

// File: rtl/eqw_burst_seq.sv
module eqw_burst_seq #(
  parameter int NUM_BANDS = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   go,
  input  logic                   addr_sel,
  input  logic [NUM_BANDS*8-1:0] band_bytes,
  input  logic                   ack_err,
  input  logic                   out_ready,
  output logic [7:0]             out_data,
  output logic                   out_valid,
  output logic                   out_first,
  output logic                   out_last,
  output logic                   busy,
  output logic                   err
);
  localparam int NBYTES   = NUM_BANDS + 2;
  localparam int IDX_W    = $clog2(NBYTES);
  localparam int LAST_IDX = NBYTES - 1;

  logic [7:0]       slot_q [NBYTES];
  logic [IDX_W-1:0] idx_q;
  logic             busy_q;
  logic             err_q;

  // Named events for the assertions below.
  wire start_ev  = go && !busy_q;
  wire abort_ev  = busy_q && ack_err;
  wire accept_ev = busy_q && out_ready && !ack_err;
  wire final_ev  = accept_ev && (idx_q == IDX_W'(LAST_IDX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= abort_ev;
      if (start_ev) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (abort_ev) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else if (final_ev) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else if (accept_ev) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // Frame slots, captured on the start event.
  always_ff @(posedge clk) begin
    if (start_ev) begin
      slot_q[0] <= {6'b100001, addr_sel, 1'b0};
      slot_q[1] <= 8'h00;
    end
  end

  for (genvar k = 0; k < NUM_BANDS; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (start_ev) slot_q[k+2] <= band_bytes[k*8 +: 8];
    end
  end

  assign out_valid = busy_q;
  assign out_data  = busy_q ? slot_q[idx_q] : 8'h00;
  assign out_first = busy_q && (idx_q == '0);
  assign out_last  = busy_q && (idx_q == IDX_W'(LAST_IDX));
  assign busy      = busy_q;
  assign err       = err_q;

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready && !ack_err) |=> (out_valid && $stable(out_data))); // R8
  AST_MARK_EXCL: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !(out_first && out_last)); // R8
  AST_BIT3_LOW: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !out_data[3]); // R6
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_first && out_data != 8'h00) |-> (out_data[6:4] <= 3'd5 && out_data[2:0] <= 3'd5)); // R5
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(go)); // R9
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) err |=> !err); // R10
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n) err |-> (!busy && !out_valid)); // R10
endmodule

// File: rtl/eq_burst_writer.sv
module eq_burst_writer
  import eqw_pkg::*;
#(
  parameter int NUM_BANDS = 5,
  parameter int POS_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       go,
  input  logic [1:0]                 qmode,
  input  logic                       bypass_req,
  input  logic                       addr_sel,
  input  logic [NUM_BANDS*POS_W-1:0] band_pos,
  input  logic                       ack_err,
  input  logic                       out_ready,
  output logic [7:0]                 out_data,
  output logic                       out_valid,
  output logic                       out_first,
  output logic                       out_last,
  output logic                       busy,
  output logic                       err
);
  logic [NUM_BANDS*8-1:0] band_bytes;

  for (genvar k = 0; k < NUM_BANDS; k++) begin : g_band
    steps_t st;
    eqw_band_enc #(.POS_W(POS_W)) u_enc (
      .pos   ($signed(band_pos[k*POS_W +: POS_W])),
      .mode  (qmode),
      .steps (st)
    );
    if (k == 0) begin : g_first
      assign band_bytes[k*8 +: 8] = pack_band(st, bypass_req);
    end else begin : g_rest
      assign band_bytes[k*8 +: 8] = pack_band(st, 1'b0);
    end
  end

  eqw_burst_seq #(.NUM_BANDS(NUM_BANDS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .addr_sel   (addr_sel),
    .band_bytes (band_bytes),
    .ack_err    (ack_err),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .out_first  (out_first),
    .out_last   (out_last),
    .busy       (busy),
    .err        (err)
  );
endmodule

// File: tb/tb_eq_burst_writer.sv
`timescale 1ns/1ps
module tb_eq_burst_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [1:0]  qmode = 2'd0;
  logic        bypass_req = 1'b0;
  logic        addr_sel = 1'b0;
  logic [19:0] band_pos;
  logic        ack_err = 1'b0;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_valid, out_first, out_last, busy, err;
  int          pos_i [5];
  int          vectors = 0;
  int          fails = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int k = 0; k < 5; k++) band_pos[k*4 +: 4] = 4'(pos_i[k]);
  end

  eq_burst_writer dut (
    .clk(clk), .rst_n(rst_n), .go(go), .qmode(qmode), .bypass_req(bypass_req),
    .addr_sel(addr_sel), .band_pos(band_pos), .ack_err(ack_err), .out_ready(out_ready),
    .out_data(out_data), .out_valid(out_valid), .out_first(out_first),
    .out_last(out_last), .busy(busy), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected step pair, restated from the requirement tables.
  function automatic int exp_byte(int raw, int mode, bit top);
    int pv, b, c;
    int qb [11] = '{0, 1, 2, 2, 2, 0, 3, 4, 5, 5, 5};
    int qc [11] = '{5, 5, 5, 4, 3, 0, 2, 2, 2, 1, 0};
    pv = (raw > 5) ? 5 : ((raw < -5) ? -5 : raw);           // R5
    if (pv == 0) begin b = 0; c = 0; end                      // R1
    else if (mode == 1) begin                                 // R3
      b = (pv > 0) ? 5 : 5 + pv;
      c = (pv > 0) ? 5 - pv : 5;
    end else if (mode == 2) begin                             // R4
      b = qb[pv + 5];
      c = qc[pv + 5];
    end else begin                                            // R2
      b = (pv > 0) ? pv : 0;
      c = (pv < 0) ? -pv : 0;
    end
    return (int'(top) << 7) | (b << 4) | c;                   // R6
  endfunction

  function automatic string band_tag(int raw, int mode);
    if (raw > 5 || raw < -5) return "R5/R6";
    if (raw == 0) return "R1/R6";
    if (mode == 1) return "R3/R6";
    if (mode == 2) return "R4/R6";
    return "R2/R6";
  endfunction

  task automatic run_burst(input int mode, input bit byp, input bit sel, input bit inject, input int seed);
    int    expv [7];
    string tags [7];
    int    got, cyc;
    expv[0] = sel ? 8'h86 : 8'h84; tags[0] = "R7";
    expv[1] = 8'h00;               tags[1] = "R7";
    for (int k = 0; k < 5; k++) begin
      expv[k+2] = exp_byte(pos_i[k], mode, byp && (k == 0));
      tags[k+2] = band_tag(pos_i[k], mode);
    end
    @(negedge clk);
    qmode = 2'(mode); bypass_req = byp; addr_sel = sel; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    chk(busy == 1'b1, "R9 busy after go", int'(busy), 1);
    got = 0; cyc = 0;
    while (got < 7 && cyc < 100) begin
      out_ready = ((cyc + seed) % 3) != 0;
      go = inject && (got == 3);
      if (go) begin
        for (int k = 0; k < 5; k++) pos_i[k] = 7;
        addr_sel = ~sel;
      end
      if (out_valid && out_ready) begin
        chk(out_data == 8'(expv[got]), tags[got], int'(out_data), expv[got]);
        chk(out_first == (got == 0) && out_last == (got == 6), "R8 markers",
            int'({out_first, out_last}), int'({got == 0, got == 6}));
        got++;
      end else begin
        chk(out_valid == 1'b1, "R8 valid held", int'(out_valid), 1);
      end
      cyc++;
      @(negedge clk);
    end
    go = 1'b0; out_ready = 1'b0;
    chk(got == 7, "R7 byte count", got, 7);
    chk(busy == 1'b0 && out_valid == 1'b0, "R9 idle after last", int'({busy, out_valid}), 0);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 5; k++) pos_i[k] = 0;
    repeat (3) @(negedge clk);
    chk({busy, out_valid, out_first, out_last, err} == 5'b0, "R11 reset",
        int'({busy, out_valid, out_first, out_last, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, out_valid, err} == 3'b0, "R11 idle", int'({busy, out_valid, err}), 0);

    // R1: flat positions with bypass set.
    run_burst(1, 1'b1, 1'b0, 1'b0, 0);

    // Sweep every 4-bit position in every mode; rotate values across bands.
    for (int mode = 0; mode < 4; mode++) begin
      for (int v = -8; v < 8; v++) begin
        for (int k = 0; k < 5; k++) pos_i[k] = ((v + 8 + 3 * k) % 16) - 8;
        run_burst(mode, v[0], v[1], (v == 0), v + 8 + mode);
      end
    end

    // R10: abort mid-frame.
    for (int k = 0; k < 5; k++) pos_i[k] = 2;
    @(negedge clk);
    go = 1'b1; qmode = 2'd0;
    @(negedge clk);
    go = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0; ack_err = 1'b1;
    @(negedge clk);
    ack_err = 1'b0;
    chk(err == 1'b1, "R10 err pulse", int'(err), 1);
    chk(busy == 1'b0 && out_valid == 1'b0, "R10 idle after abort", int'({busy, out_valid}), 0);
    @(negedge clk);
    chk(err == 1'b0, "R10 err one cycle", int'(err), 0);
    chk(busy == 1'b0, "R10 stays idle", int'(busy), 0);

    // Recovery after abort.
    for (int k = 0; k < 5; k++) pos_i[k] = -k;
    run_burst(2, 1'b0, 1'b1, 1'b0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule